// File: doc/BRIEF.md
# IR-Drop Aware Command Budget Scheduler

This block sits in the command path of a controller for a 3D-stacked DRAM. Each cycle it looks at a small queue of pending commands, and each command is tagged with a type and a leaf region of the device. It then picks at most one command to issue. Each command costs current in proportion to its type. The block admits a command only when the leaf region it targets, and the parent group that encloses that leaf, both stay within programmable limits once the command's weight is added. A charged weight stays on the region's account for a fixed window of cycles and then drains away. This models the supply droop a burst of nearby activity causes.

Among the commands that fit, the one that has waited longest wins. A request that has waited much longer than the queue's average becomes starving. While any request is starving, only starving requests may issue, so a busy neighbour cannot keep taking the budget the starving request needs. The queue itself is outside the block: the requester holds a slot valid until it sees the grant for that slot.

Top module: `irdrop_cmd_sched`

## Requirements
- R1: While `rst_n` is low no grant is given. Reset release is synchronised over two clock edges, so the first grant can appear in the cycle after the second rising edge that follows release. After reset every region account is empty.
- R2: Command codes are 0 activate (weight 3), 1 column read (weight 6), 2 column write (weight 6) and 3 precharge (weight 1). Slot i's code is `req_cmd[2i+1:2i]`.
- R3: A command to leaf L is granted only if the charge now on L plus the command's weight is at most `leaf_limit`.
- R4: Leaves 2g and 2g+1 form group g. A command is granted only if the sum of both leaves' charges in its group, plus its weight, is at most `group_limit`. Slot i's leaf is `req_region[2i+1:2i]`.
- R5: A weight charged when a command is granted in cycle c is counted in cycles c+1 through c+WINDOW. It no longer counts from cycle c+WINDOW+1.
- R6: At most one command is granted per cycle, and only to a valid slot. A cycle with no grant adds no charge.
- R7: Among eligible requests that fit, the oldest is granted. On equal age, the lowest slot index wins.
- R8: A valid request is starving when its age times the number of valid requests exceeds twice the sum of their ages. While any valid request is starving, no request that is not starving is granted.
- R9: A slot's age is 0 in its first valid cycle and grows by one each cycle it stays valid without a grant. It returns to 0 on a grant or whenever the slot is not valid.
- R10: With a grant, `grant_idx` names the chosen slot, and `issue_cmd` and `issue_region` carry that slot's code and leaf in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leaf_limit | input | BUD_W | Current budget of each leaf region |
| group_limit | input | BUD_W | Current budget of each pair of leaves |
| req_valid | input | NREQ | Slot holds a pending command |
| req_cmd | input | 2*NREQ | Command code per slot |
| req_region | input | LEAF_W*NREQ | Leaf region per slot |
| grant_valid | output | 1 | A command issues this cycle |
| grant_idx | output | IDX_W | Slot that issues |
| issue_cmd | output | 2 | Code of the issued command |
| issue_region | output | LEAF_W | Leaf of the issued command |

## Verification
The assertions check, on every cycle, that any grant is to a valid slot and stays within both the leaf limit and the group limit at the moment it issues. They also check that a cycle without a grant never raises any account, and that a grant made while some request is starving goes to a starving request. Only the bench scenarios can show the exact grant-and-refund rhythm each command weight produces over the window, the age-then-index order, the starvation gate holding back a fitting neighbour, and the clearing of an age when its slot drops.

// File: rtl/irs_pkg.sv
`timescale 1ns/1ps
package irs_pkg;

  localparam int WGT_W = 3;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // R2: current cost of each command type
  function automatic logic [WGT_W-1:0] cmd_weight(input logic [1:0] code);
    logic [WGT_W-1:0] w;
    case (cmd_e'(code))
      CMD_ACT: w = 3'd3;
      CMD_RD:  w = 3'd6;
      CMD_WR:  w = 3'd6;
      default: w = 3'd1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/irs_age_track.sv
`timescale 1ns/1ps
module irs_age_track #(
  parameter int NREQ  = 4,
  parameter int AGE_W = 8,
  localparam int IDX_W = $clog2(NREQ),
  localparam int CNT_W = $clog2(NREQ + 1),
  localparam int SUM_W = AGE_W + CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREQ-1:0]       valid,
  input  logic                  grant_valid,
  input  logic [IDX_W-1:0]      grant_idx,
  output logic [NREQ*AGE_W-1:0] age_flat,
  output logic [NREQ-1:0]       starving
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_q [NREQ];
  logic [AGE_W-1:0] age_d [NREQ];
  logic [SUM_W-1:0] age_sum;
  logic [CNT_W-1:0] live_cnt;

  // R9: next-state of each slot's waiting time
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      if (!valid[i] || (grant_valid && grant_idx == IDX_W'(i)))
        age_d[i] = '0;
      else if (age_q[i] != AGE_MAX)
        age_d[i] = age_q[i] + 1'b1;
      else
        age_d[i] = age_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) age_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREQ; i++) age_q[i] <= age_d[i];
    end
  end

  // R8: age * count > 2 * sum, a divide-free form of "over twice the mean"
  always_comb begin
    age_sum  = '0;
    live_cnt = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (valid[i]) begin
        age_sum  = age_sum + SUM_W'(age_q[i]);
        live_cnt = live_cnt + 1'b1;
      end
    end
    for (int i = 0; i < NREQ; i++) begin
      starving[i] = valid[i] &&
                    ((SUM_W'(age_q[i]) * SUM_W'(live_cnt)) > (age_sum << 1));
      age_flat[i*AGE_W +: AGE_W] = age_q[i];
    end
  end

endmodule

// File: rtl/irs_budget_ledger.sv
`timescale 1ns/1ps
module irs_budget_ledger
  import irs_pkg::*;
#(
  parameter int NLEAF  = 4,
  parameter int WINDOW = 8,
  parameter int BUD_W  = 8,
  localparam int LEAF_W = $clog2(NLEAF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   charge_en,
  input  logic [LEAF_W-1:0]      charge_leaf,
  input  logic [WGT_W-1:0]       charge_wgt,
  output logic [NLEAF*BUD_W-1:0] usage_flat
);

  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    logic [WGT_W-1:0] pipe_q [WINDOW];
    logic [WGT_W-1:0] pipe_d [WINDOW];
    logic [WGT_W-1:0] charge_here;
    logic [BUD_W-1:0] use_q;
    logic [BUD_W-1:0] use_d;

    // R5: charge enters the delay line and leaves it WINDOW edges later
    always_comb begin
      charge_here = (charge_en && charge_leaf == LEAF_W'(g)) ? charge_wgt : '0;
      pipe_d[0]   = charge_here;
      for (int k = 1; k < WINDOW; k++) pipe_d[k] = pipe_q[k-1];
      use_d = use_q + BUD_W'(charge_here) - BUD_W'(pipe_q[WINDOW-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_q <= '0;
        for (int k = 0; k < WINDOW; k++) pipe_q[k] <= '0;
      end else begin
        use_q <= use_d;
        for (int k = 0; k < WINDOW; k++) pipe_q[k] <= pipe_d[k];
      end
    end

    assign usage_flat[g*BUD_W +: BUD_W] = use_q;
  end

endmodule

// File: rtl/irs_pick.sv
`timescale 1ns/1ps
module irs_pick #(
  parameter int NREQ  = 4,
  parameter int AGE_W = 8,
  localparam int IDX_W = $clog2(NREQ)
) (
  input  logic [NREQ-1:0]       valid,
  input  logic [NREQ-1:0]       fits,
  input  logic [NREQ-1:0]       starving,
  input  logic [NREQ*AGE_W-1:0] age_flat,
  output logic                  pick_valid,
  output logic [IDX_W-1:0]      pick_idx
);

  logic [NREQ-1:0]  eligible;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    // R8: a starving request shuts out every non-starving one
    if (|(valid & starving)) eligible = valid & fits & starving;
    else                     eligible = valid & fits;

    // R7: strictly older replaces, so ties keep the lower index
    pick_valid = 1'b0;
    pick_idx   = '0;
    best_age   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (eligible[i] && (!pick_valid || age_flat[i*AGE_W +: AGE_W] > best_age)) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(i);
        best_age   = age_flat[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/irdrop_cmd_sched.sv
`timescale 1ns/1ps
module irdrop_cmd_sched
  import irs_pkg::*;
#(
  parameter int NREQ   = 4,
  parameter int NLEAF  = 4,
  parameter int AGE_W  = 8,
  parameter int BUD_W  = 8,
  parameter int WINDOW = 8,
  localparam int LEAF_W = $clog2(NLEAF),
  localparam int IDX_W  = $clog2(NREQ),
  localparam int CMP_W  = BUD_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BUD_W-1:0]        leaf_limit,
  input  logic [BUD_W-1:0]        group_limit,
  input  logic [NREQ-1:0]         req_valid,
  input  logic [2*NREQ-1:0]       req_cmd,
  input  logic [LEAF_W*NREQ-1:0]  req_region,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_idx,
  output logic [1:0]              issue_cmd,
  output logic [LEAF_W-1:0]       issue_region
);

  // R1: asynchronous assertion, release aligned over two edges
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NLEAF*BUD_W-1:0] usage_flat;
  logic [NREQ*AGE_W-1:0]  age_flat;
  logic [NREQ-1:0]        starv_vec;
  logic [NREQ-1:0]        fit_vec;
  logic                   pick_valid;
  logic [IDX_W-1:0]       pick_idx;

  // R3, R4: leaf and enclosing-group admission for each slot
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      logic [LEAF_W-1:0] leaf;
      logic [LEAF_W-1:0] lo_leaf;
      logic [LEAF_W-1:0] hi_leaf;
      logic [CMP_W-1:0]  wgt;
      logic [CMP_W-1:0]  leaf_use;
      logic [CMP_W-1:0]  grp_use;
      leaf     = req_region[i*LEAF_W +: LEAF_W];
      lo_leaf  = {leaf[LEAF_W-1:1], 1'b0};
      hi_leaf  = {leaf[LEAF_W-1:1], 1'b1};
      wgt      = CMP_W'(cmd_weight(req_cmd[2*i +: 2]));
      leaf_use = CMP_W'(usage_flat[leaf*BUD_W +: BUD_W]);
      grp_use  = CMP_W'(usage_flat[lo_leaf*BUD_W +: BUD_W]) +
                 CMP_W'(usage_flat[hi_leaf*BUD_W +: BUD_W]);
      fit_vec[i] = (leaf_use + wgt <= CMP_W'(leaf_limit)) &&
                   (grp_use  + wgt <= CMP_W'(group_limit));
    end
  end

  irs_age_track #(.NREQ(NREQ), .AGE_W(AGE_W)) u_age (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .valid       (req_valid),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .age_flat    (age_flat),
    .starving    (starv_vec)
  );

  irs_pick #(.NREQ(NREQ), .AGE_W(AGE_W)) u_pick (
    .valid      (req_valid),
    .fits       (fit_vec),
    .starving   (starv_vec),
    .age_flat   (age_flat),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  // R6, R10: single grant and the chosen slot's fields
  always_comb begin
    grant_valid  = rst_sync_n && pick_valid;
    grant_idx    = pick_idx;
    issue_cmd    = req_cmd[pick_idx*2 +: 2];
    issue_region = req_region[pick_idx*LEAF_W +: LEAF_W];
  end

  irs_budget_ledger #(.NLEAF(NLEAF), .WINDOW(WINDOW), .BUD_W(BUD_W)) u_ledger (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .charge_en   (grant_valid),
    .charge_leaf (issue_region),
    .charge_wgt  (cmd_weight(issue_cmd)),
    .usage_flat  (usage_flat)
  );

endmodule

// File: rtl/irs_sched_chk.sv
`timescale 1ns/1ps
module irs_sched_chk
  import irs_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int NLEAF = 4,
  parameter int BUD_W = 8,
  localparam int LEAF_W = $clog2(NLEAF),
  localparam int IDX_W  = $clog2(NREQ),
  localparam int CMP_W  = BUD_W + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NREQ-1:0]        req_valid,
  input logic                   grant_valid,
  input logic [IDX_W-1:0]       grant_idx,
  input logic [1:0]             issue_cmd,
  input logic [LEAF_W-1:0]      issue_region,
  input logic [BUD_W-1:0]       leaf_limit,
  input logic [BUD_W-1:0]       group_limit,
  input logic [NLEAF*BUD_W-1:0] usage_flat,
  input logic [NREQ-1:0]        starving
);

  logic [CMP_W-1:0] iss_wgt;
  logic [CMP_W-1:0] iss_leaf_use;
  logic [CMP_W-1:0] iss_grp_use;

  always_comb begin
    iss_wgt      = CMP_W'(cmd_weight(issue_cmd));
    iss_leaf_use = CMP_W'(usage_flat[issue_region*BUD_W +: BUD_W]);
    iss_grp_use  = CMP_W'(usage_flat[{issue_region[LEAF_W-1:1], 1'b0}*BUD_W +: BUD_W]) +
                   CMP_W'(usage_flat[{issue_region[LEAF_W-1:1], 1'b1}*BUD_W +: BUD_W]);
  end

  // R1
  no_grant_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !grant_valid);

  // R6
  grant_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req_valid[grant_idx]);

  // R3
  leaf_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (iss_leaf_use + iss_wgt <= CMP_W'(leaf_limit)));

  // R4
  group_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (iss_grp_use + iss_wgt <= CMP_W'(group_limit)));

  // R8
  starving_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && |(req_valid & starving)) |-> starving[grant_idx]);

  for (genvar g = 0; g < NLEAF; g++) begin : g_idle
    // R6
    idle_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |=> usage_flat[g*BUD_W +: BUD_W] <= $past(usage_flat[g*BUD_W +: BUD_W]));
  end

endmodule

bind irdrop_cmd_sched irs_sched_chk #(.NREQ(NREQ), .NLEAF(NLEAF), .BUD_W(BUD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .grant_valid  (grant_valid),
  .grant_idx    (grant_idx),
  .issue_cmd    (issue_cmd),
  .issue_region (issue_region),
  .leaf_limit   (leaf_limit),
  .group_limit  (group_limit),
  .usage_flat   (usage_flat),
  .starving     (starv_vec)
);

// File: tb/tb_irdrop_cmd_sched.sv
`timescale 1ns/1ps
module tb_irdrop_cmd_sched;

  localparam int NREQ = 4;
  localparam int WINDOW = 8;

  logic       clk;
  logic       rst_n;
  logic [7:0] leaf_limit;
  logic [7:0] group_limit;
  logic [3:0] req_valid;
  logic [7:0] req_cmd;
  logic [7:0] req_region;
  logic       grant_valid;
  logic [1:0] grant_idx;
  logic [1:0] issue_cmd;
  logic [1:0] issue_region;

  int errors = 0;
  int checks = 0;

  irdrop_cmd_sched dut (
    .clk(clk), .rst_n(rst_n), .leaf_limit(leaf_limit), .group_limit(group_limit),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_region(req_region),
    .grant_valid(grant_valid), .grant_idx(grant_idx),
    .issue_cmd(issue_cmd), .issue_region(issue_region)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0] v;
    logic [7:0] cmd;
    logic [7:0] rgn;
    logic [7:0] ll;
    logic [7:0] gl;
    logic       gv;
    logic [1:0] idx;
    logic [3:0] tag;
  } vec_t;

  // codes: 0 ACT, 1 RD, 2 WR, 3 PRE; fields packed slot3..slot0
  localparam vec_t VECS [8] = '{
    '{4'b0000, 8'h00, 8'h00, 8'd6, 8'd12, 1'b0, 2'd0, 4'd6},
    '{4'b0001, 8'b00_00_00_01, 8'h00, 8'd6, 8'd12, 1'b1, 2'd0, 4'd2},
    '{4'b0001, 8'b00_00_00_01, 8'h00, 8'd5, 8'd12, 1'b0, 2'd0, 4'd3},
    '{4'b0011, 8'b00_00_00_01, 8'b00_00_01_00, 8'd5, 8'd12, 1'b1, 2'd1, 4'd3},
    '{4'b0101, 8'b00_11_00_10, 8'b00_11_00_10, 8'd8, 8'd5, 1'b1, 2'd2, 4'd4},
    '{4'b1111, 8'h00, 8'b11_10_01_00, 8'd6, 8'd12, 1'b1, 2'd0, 4'd7},
    '{4'b1000, 8'h00, 8'b11_00_00_00, 8'd3, 8'd3, 1'b1, 2'd3, 4'd3},
    '{4'b0010, 8'h00, 8'b00_00_01_00, 8'd2, 8'd12, 1'b0, 2'd0, 4'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [7:0] c, input logic [7:0] r);
    @(negedge clk);
    req_valid  = v;
    req_cmd    = c;
    req_region = r;
    #1;
  endtask

  task automatic expect_grant(input string req, input logic gv, input logic [1:0] idx);
    chk(grant_valid == gv, req, "grant_valid", int'(grant_valid), int'(gv));
    if (gv) chk(grant_idx == idx, req, "grant_idx", int'(grant_idx), int'(idx));
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = '0;
    repeat (WINDOW + 1) @(negedge clk);
  endtask

  // R2 / R5: one slot held on leaf 0, grant rhythm over 12 cycles
  task automatic rhythm(input logic [1:0] code, input logic [11:0] exp_pat, input string what);
    drain();
    leaf_limit  = 8'd6;
    group_limit = 8'd255;
    for (int c = 0; c < 12; c++) begin
      drive(4'b0001, {6'd0, code}, 8'h00);
      chk(grant_valid == exp_pat[c], "R2/R5", $sformatf("%s cycle %0d", what, c),
          int'(grant_valid), int'(exp_pat[c]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    leaf_limit  = 8'd6;
    group_limit = 8'd255;
    req_valid   = 4'b0001;
    req_cmd     = 8'b00_00_00_11;
    req_region  = 8'h00;

    // R1: held in reset with a pending request
    repeat (3) @(negedge clk);
    #1;
    expect_grant("R1", 1'b0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_grant("R1", 1'b0, 2'd0);
    @(negedge clk); #1;
    expect_grant("R1", 1'b0, 2'd0);
    @(negedge clk); #1;
    expect_grant("R1", 1'b1, 2'd0);

    // table walk: each vector from empty accounts and zero ages
    for (int n = 0; n < 8; n++) begin
      drain();
      leaf_limit  = VECS[n].ll;
      group_limit = VECS[n].gl;
      drive(VECS[n].v, VECS[n].cmd, VECS[n].rgn);
      expect_grant($sformatf("R%0d vec%0d", VECS[n].tag, n), VECS[n].gv, VECS[n].idx);
      if (VECS[n].gv && grant_valid) begin
        chk(issue_cmd == VECS[n].cmd[2*VECS[n].idx +: 2], "R10", "issue_cmd",
            int'(issue_cmd), int'(VECS[n].cmd[2*VECS[n].idx +: 2]));
        chk(issue_region == VECS[n].rgn[2*VECS[n].idx +: 2], "R10", "issue_region",
            int'(issue_region), int'(VECS[n].rgn[2*VECS[n].idx +: 2]));
      end
    end

    // R2 / R5: bit c is cycle c; window of 8 cycles on a limit of 6
    rhythm(2'd0, 12'b0110_0000_0011, "activate");
    rhythm(2'd1, 12'b0010_0000_0001, "read");
    rhythm(2'd2, 12'b0010_0000_0001, "write");
    rhythm(2'd3, 12'b1110_0011_1111, "precharge");

    // R4 / R7: leaves 0 and 1 share group 0
    drain();
    leaf_limit  = 8'd6;
    group_limit = 8'd6;
    drive(4'b0011, 8'h00, 8'b00_00_01_00);
    expect_grant("R7 tie", 1'b1, 2'd0);
    drive(4'b0011, 8'h00, 8'b00_00_01_00);
    expect_grant("R7 older", 1'b1, 2'd1);
    drive(4'b0011, 8'h00, 8'b00_00_01_00);
    expect_grant("R4 group full", 1'b0, 2'd0);

    // R9: age clears when the slot drops
    drain();
    leaf_limit  = 8'd6;
    group_limit = 8'd255;
    drive(4'b0010, 8'b00_00_01_00, 8'b00_00_01_00);
    expect_grant("R9 first", 1'b1, 2'd1);
    drive(4'b0010, 8'b00_00_01_00, 8'b00_00_01_00);
    expect_grant("R3 leaf full", 1'b0, 2'd0);
    drive(4'b0010, 8'b00_00_01_00, 8'b00_00_01_00);
    drive(4'b0010, 8'b00_00_01_00, 8'b00_00_01_00);
    drive(4'b0000, 8'h00, 8'h00);
    drive(4'b0011, 8'b00_00_11_11, 8'h00);
    expect_grant("R9 cleared", 1'b1, 2'd0);
    drive(4'b0011, 8'b00_00_11_11, 8'h00);
    expect_grant("R9 aged", 1'b1, 2'd1);

    // R8: a starving read holds back fitting precharges
    drain();
    leaf_limit  = 8'd8;
    group_limit = 8'd20;
    drive(4'b0001, 8'h00, 8'h00);
    expect_grant("R8 setup", 1'b1, 2'd0);
    drive(4'b0001, 8'h00, 8'h00);
    expect_grant("R8 setup", 1'b1, 2'd0);
    drive(4'b1111, 8'b11_11_11_01, 8'b10_11_10_00);
    expect_grant("R8 c2", 1'b1, 2'd1);
    drive(4'b1111, 8'b11_11_11_01, 8'b10_11_10_00);
    expect_grant("R8 c3", 1'b1, 2'd2);
    drive(4'b1111, 8'b11_11_11_01, 8'b10_11_10_00);
    expect_grant("R8 c4", 1'b1, 2'd3);
    drive(4'b1111, 8'b11_11_11_01, 8'b10_11_10_00);
    expect_grant("R8 c5", 1'b1, 2'd1);
    drive(4'b1111, 8'b11_11_11_01, 8'b10_11_10_00);
    expect_grant("R8 starving blocks", 1'b0, 2'd0);

    // R6: nothing valid, nothing granted
    drive(4'b0000, 8'h00, 8'h00);
    expect_grant("R6 idle", 1'b0, 2'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule